// File: doc/BRIEF.md
# Ring queue address translator

This block manages one circular queue that lives in external memory. Producers and consumers never see the queue's pointers. They issue push or pop requests as if writing to or reading from a single fixed location. The block turns each request into a memory request. A push is sent to the address of the queue's tail element and a pop to its head element. The block then advances its indices and occupancy count.

A configuration port loads the base address, the ring length in elements, an element-size code and an operating mode. An invalid setting is refused and leaves the previous configuration in place. A valid load, or a pulse on the clear input, empties the ring.

In the two message-style modes the block also accepts two reverse operations: insertion in front of the head and removal from behind the tail. The block continuously reports occupancy, free space and a full flag.

Top module: `ring_queue_accel`

## Requirements
- R1: An accepted push produces, one cycle later, a memory write at base + tail × step, and the tail then advances. An accepted pop produces a memory read at base + head × step, and the head then advances.
- R2: The element-size code selects a step of 4 << code bytes for codes 0 to 6. A configuration write with code 7 raises `cfg_err` on the following cycle and changes nothing.
- R3: Mode code 0 is exposed ring, 1 is message and 2 is credentials. In credentials mode the step is doubled. A configuration write with mode 3 raises `cfg_err` and changes nothing.
- R4: In modes 1 and 2, a push with `push_at_head` first moves the head back by one (modulo length) and writes there. A pop with `pop_at_tail` first moves the tail back by one and reads there. Occupancy moves by one in each case.
- R5: In mode 0, a push with `push_at_head` or a pop with `pop_at_tail` raises `op_err` one cycle later. It issues no memory request and changes no index or occupancy.
- R6: A push while occupancy equals the length, or a pop while occupancy is zero, raises `op_err` and issues no memory request. Indices and occupancy are unchanged.
- R7: A pulse on `ring_clr`, or any accepted configuration write, sets occupancy and both indices to zero.
- R8: When pop and push are both valid in one cycle, the pop is taken and `push_ready` is low. The push is taken on a later cycle.
- R9: `occupancy` counts the stored elements, `free_count` equals length minus occupancy, and `full` is high exactly when they are equal. After reset the occupancy is 0, the length is MAX_ELEMS, the base is 0, the code is 0 and the mode is 0.
- R10: Both indices wrap from length−1 to 0 going forward, and from 0 to length−1 going back.
- R11: A configuration write with a length of 0, or a length above MAX_ELEMS, raises `cfg_err` and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Load configuration |
| cfg_base | input | AW | Ring base address |
| cfg_size | input | clog2(MAX_ELEMS+1) | Ring length in elements |
| cfg_esize | input | 3 | Element-size code |
| cfg_mode | input | 2 | Operating mode code |
| ring_clr | input | 1 | Empty the ring |
| cfg_err | output | 1 | Previous configuration write refused |
| push_valid | input | 1 | Push request |
| push_at_head | input | 1 | Push inserts in front of head |
| push_ready | output | 1 | Push taken this cycle |
| pop_valid | input | 1 | Pop request |
| pop_at_tail | input | 1 | Pop removes from behind tail |
| pop_ready | output | 1 | Pop taken this cycle |
| mem_req_valid | output | 1 | Translated memory request |
| mem_req_write | output | 1 | 1 = write (push), 0 = read (pop) |
| mem_req_addr | output | AW | Translated address |
| op_err | output | 1 | Previous request refused |
| occupancy | output | clog2(MAX_ELEMS+1) | Stored elements |
| free_count | output | clog2(MAX_ELEMS+1) | Empty slots |
| full | output | 1 | Ring full |

## Verification
Plain pushes and pops are run through a short ring until it fills and then wraps. This separates correct tail and head addressing from an off-by-one in the wrap point, and shows that the full and empty refusals leave the state intact. Mixed head-insertion and tail-removal sequences in message mode tell "decrement then use" apart from "use then decrement". The same requests in exposed mode must come back refused. A credentials-mode ring with a non-unit element code tells the doubled step apart from the plain one. Simultaneous push and pop show the fixed ordering, and invalid size, mode and length codes are each shown to leave the previous configuration in effect.

// File: rtl/rqa_pkg.sv
package rqa_pkg;
  typedef enum logic [1:0] {
    MODE_EXPOSED = 2'd0,
    MODE_MSG     = 2'd1,
    MODE_CRED    = 2'd2,
    MODE_BAD     = 2'd3
  } ring_mode_e;

  // log2 of the address step for one element
  function automatic logic [3:0] step_shift(logic [2:0] esz, ring_mode_e m);
    return 4'(esz) + 4'd2 + ((m == MODE_CRED) ? 4'd1 : 4'd0);
  endfunction

  function automatic logic codes_ok(logic [2:0] esz, logic [1:0] mode);
    return (esz != 3'd7) && (mode != 2'd3);
  endfunction
endpackage

// File: rtl/rqa_cfg_regs.sv
module rqa_cfg_regs
  import rqa_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_ELEMS = 16,
  parameter int CW        = $clog2(MAX_ELEMS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_base,
  input  logic [CW-1:0] cfg_size,
  input  logic [2:0]    cfg_esize,
  input  logic [1:0]    cfg_mode,
  output logic [AW-1:0] base_q,
  output logic [CW-1:0] size_q,
  output logic [2:0]    esz_q,
  output ring_mode_e    mode_q,
  output logic          cfg_load,
  output logic          cfg_err
);
  logic size_ok;
  assign size_ok  = (cfg_size != '0) && (cfg_size <= CW'(MAX_ELEMS));
  assign cfg_load = cfg_we && size_ok && codes_ok(cfg_esize, cfg_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      size_q  <= CW'(MAX_ELEMS);
      esz_q   <= 3'd0;
      mode_q  <= MODE_EXPOSED;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= cfg_we && !cfg_load;
      if (cfg_load) begin
        base_q <= cfg_base;
        size_q <= cfg_size;
        esz_q  <= cfg_esize;
        mode_q <= ring_mode_e'(cfg_mode);
      end
    end
  end

  a_r2_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_esize == 3'd7) |=> (cfg_err && $stable(esz_q) && $stable(base_q)));
  a_r3_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_mode == 2'd3) |=> (cfg_err && $stable(mode_q)));
  a_r11_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_size == '0) |=> (cfg_err && $stable(size_q)));
endmodule

// File: rtl/rqa_ring_ctrl.sv
module rqa_ring_ctrl
  import rqa_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 4,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] size,
  input  logic [2:0]    esz,
  input  ring_mode_e    mode,
  input  logic          go_pop,
  input  logic          go_push,
  input  logic          alt,
  output logic          mem_req_valid,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic          op_err,
  output logic [CW-1:0] occ
);
  logic [IW-1:0] head, tail, head_n, tail_n, idx;
  logic          any_op, bad_mode, bad_level, refuse, accept;

  function automatic logic [IW-1:0] idx_inc(logic [IW-1:0] i, logic [CW-1:0] n);
    return (CW'(i) == n - CW'(1)) ? '0 : i + IW'(1);
  endfunction

  function automatic logic [IW-1:0] idx_dec(logic [IW-1:0] i, logic [CW-1:0] n);
    return (i == '0) ? IW'(n - CW'(1)) : i - IW'(1);
  endfunction

  function automatic logic [AW-1:0] xlate(logic [AW-1:0] b, logic [IW-1:0] i,
                                          logic [2:0] e, ring_mode_e m);
    return b + (AW'(i) << step_shift(e, m));
  endfunction

  assign any_op    = go_pop || go_push;
  assign bad_mode  = alt && (mode == MODE_EXPOSED);
  assign bad_level = go_pop ? (occ == '0) : (occ == size);
  assign refuse    = any_op && (bad_mode || bad_level);
  assign accept    = any_op && !refuse;

  always_comb begin
    head_n = head;
    tail_n = tail;
    idx    = head;
    case ({go_pop, alt})
      2'b10: begin idx = head;               head_n = idx_inc(head, size); end
      2'b11: begin idx = idx_dec(tail, size); tail_n = idx;                end
      2'b00: begin idx = tail;               tail_n = idx_inc(tail, size); end
      default: begin idx = idx_dec(head, size); head_n = idx;              end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head          <= '0;
      tail          <= '0;
      occ           <= '0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      op_err        <= 1'b0;
    end else if (clear) begin
      head          <= '0;
      tail          <= '0;
      occ           <= '0;
      mem_req_valid <= 1'b0;
      op_err        <= 1'b0;
    end else begin
      mem_req_valid <= accept;
      op_err        <= refuse;
      mem_req_write <= go_push;
      mem_req_addr  <= xlate(base, idx, esz, mode);
      if (accept) begin
        head <= head_n;
        tail <= tail_n;
        occ  <= go_pop ? occ - CW'(1) : occ + CW'(1);
      end
    end
  end

  a_r9_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= size);
  a_r6_refuse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (refuse && !clear) |=> ($stable(occ) && $stable(head) && $stable(tail) && op_err && !mem_req_valid));
  a_r5_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_err && mem_req_valid));
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (occ == '0 && head == '0 && tail == '0));
  a_r1_push_write: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && go_push && !clear) |=> (mem_req_valid && mem_req_write));
endmodule

// File: rtl/ring_queue_accel.sv
module ring_queue_accel
  import rqa_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_ELEMS = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [AW-1:0]                  cfg_base,
  input  logic [$clog2(MAX_ELEMS+1)-1:0] cfg_size,
  input  logic [2:0]                     cfg_esize,
  input  logic [1:0]                     cfg_mode,
  input  logic                           ring_clr,
  output logic                           cfg_err,
  input  logic                           push_valid,
  input  logic                           push_at_head,
  output logic                           push_ready,
  input  logic                           pop_valid,
  input  logic                           pop_at_tail,
  output logic                           pop_ready,
  output logic                           mem_req_valid,
  output logic                           mem_req_write,
  output logic [AW-1:0]                  mem_req_addr,
  output logic                           op_err,
  output logic [$clog2(MAX_ELEMS+1)-1:0] occupancy,
  output logic [$clog2(MAX_ELEMS+1)-1:0] free_count,
  output logic                           full
);
  localparam int IW = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1;
  localparam int CW = $clog2(MAX_ELEMS + 1);

  logic [AW-1:0] base_q;
  logic [CW-1:0] size_q;
  logic [2:0]    esz_q;
  ring_mode_e    mode_q;
  logic          cfg_load, clear, busy_cfg, pop_fire, push_fire, alt_sel;

  rqa_cfg_regs #(.AW(AW), .MAX_ELEMS(MAX_ELEMS), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_esize(cfg_esize), .cfg_mode(cfg_mode),
    .base_q(base_q), .size_q(size_q), .esz_q(esz_q), .mode_q(mode_q),
    .cfg_load(cfg_load), .cfg_err(cfg_err)
  );

  assign busy_cfg   = cfg_we || ring_clr;
  assign clear      = cfg_load || ring_clr;
  assign pop_ready  = !busy_cfg;
  assign push_ready = !busy_cfg && !pop_valid;
  assign pop_fire   = pop_valid && pop_ready;
  assign push_fire  = push_valid && push_ready;
  assign alt_sel    = pop_fire ? pop_at_tail : push_at_head;

  rqa_ring_ctrl #(.AW(AW), .IW(IW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear(clear), .base(base_q), .size(size_q),
    .esz(esz_q), .mode(mode_q), .go_pop(pop_fire), .go_push(push_fire),
    .alt(alt_sel), .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .op_err(op_err), .occ(occupancy)
  );

  assign free_count = size_q - occupancy;
  assign full       = (occupancy == size_q);

  a_r8_pop_first: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && push_valid) |-> (!push_ready && (pop_ready || busy_cfg)));
  a_r9_free_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'(free_count + occupancy) == size_q) && (full == (free_count == '0)));
endmodule

// File: tb/ring_queue_accel_tb.sv
module ring_queue_accel_tb;
  localparam int AW = 32;
  localparam int MX = 16;
  localparam int CW = $clog2(MX + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, ring_clr = 0;
  logic [AW-1:0] cfg_base = '0;
  logic [CW-1:0] cfg_size = '0;
  logic [2:0] cfg_esize = '0;
  logic [1:0] cfg_mode = '0;
  logic push_valid = 0, push_at_head = 0, pop_valid = 0, pop_at_tail = 0;
  logic cfg_err, push_ready, pop_ready, mem_req_valid, mem_req_write, op_err, full;
  logic [AW-1:0] mem_req_addr;
  logic [CW-1:0] occupancy, free_count;

  int n_run = 0, n_fail = 0;
  longint m_base = 0, m_size = MX, m_esz = 0, m_mode = 0, m_head = 0, m_tail = 0, m_occ = 0;

  always #4 clk = ~clk;

  ring_queue_accel #(.AW(AW), .MAX_ELEMS(MX)) u_dut (.*);

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint exp_addr(input longint i);
    return m_base + i * (4 * (64'd1 << m_esz)) * ((m_mode == 2) ? 2 : 1);
  endfunction

  function automatic longint fwd(input longint i);
    return (i == m_size - 1) ? 0 : i + 1;
  endfunction

  function automatic longint back(input longint i);
    return (i == 0) ? m_size - 1 : i - 1;
  endfunction

  task automatic model_op(input bit push, input bit alt, output bit err, output longint idx);
    err = (alt && m_mode == 0) || (push ? (m_occ == m_size) : (m_occ == 0));
    idx = 0;
    if (!err) begin
      if (push && !alt) begin idx = m_tail; m_tail = fwd(m_tail); end
      else if (push) begin m_head = back(m_head); idx = m_head; end
      else if (!alt) begin idx = m_head; m_head = fwd(m_head); end
      else begin m_tail = back(m_tail); idx = m_tail; end
      m_occ = push ? m_occ + 1 : m_occ - 1;
    end
  endtask

  task automatic check_result(input string req, input bit push, input bit err, input longint idx);
    check(req, "op_err", op_err, err);
    check(req, "mem_req_valid", mem_req_valid, !err);
    if (!err) begin
      check(req, "mem_req_write", mem_req_write, push);
      check(req, "mem_req_addr", mem_req_addr, exp_addr(idx));
    end
    check(req, "occupancy", occupancy, m_occ);
    check("R9", "free_count", free_count, m_size - m_occ);
    check("R9", "full", full, m_occ == m_size);
  endtask

  task automatic do_op(input bit push, input bit alt, input string req);
    bit err; longint idx;
    @(negedge clk);
    push_valid = push; push_at_head = push & alt;
    pop_valid = !push; pop_at_tail = !push & alt;
    @(posedge clk); #1;
    push_valid = 0; pop_valid = 0; push_at_head = 0; pop_at_tail = 0;
    model_op(push, alt, err, idx);
    check_result(req, push, err, idx);
  endtask

  task automatic do_cfg(input longint b, input longint sz, input longint e, input longint md, input string req);
    bit ok;
    ok = (e != 7) && (md != 3) && (sz != 0) && (sz <= MX);
    @(negedge clk);
    cfg_we = 1; cfg_base = AW'(b); cfg_size = CW'(sz); cfg_esize = 3'(e); cfg_mode = 2'(md);
    @(posedge clk); #1;
    cfg_we = 0;
    check(req, "cfg_err", cfg_err, !ok);
    if (ok) begin
      m_base = b; m_size = sz; m_esz = e; m_mode = md; m_head = 0; m_tail = 0; m_occ = 0;
    end
    check(req, "occupancy after cfg", occupancy, m_occ);
  endtask

  task automatic t_reset;
    check("R9", "reset occupancy", occupancy, 0);
    check("R9", "reset free_count", free_count, MX);
    check("R9", "reset full", full, 0);
    check("R9", "reset mem_req_valid", mem_req_valid, 0);
    check("R9", "reset cfg_err", cfg_err, 0);
    do_op(1, 0, "R9 reset base 0 step 4");
    do_op(0, 0, "R1");
  endtask

  task automatic t_config;
    do_cfg(32'h1000, 4, 2, 0, "R2 valid");
    do_cfg(32'h9000, 4, 7, 0, "R2 code 7");
    do_cfg(32'h9000, 4, 1, 3, "R3 mode 3");
    do_cfg(32'h9000, 0, 1, 0, "R11 size 0");
    do_cfg(32'h9000, 17, 1, 0, "R11 size 17");
    do_op(1, 0, "R2 step 16 kept");
    do_op(0, 0, "R1");
  endtask

  task automatic t_fill_wrap;
    for (int k = 0; k < 4; k++) do_op(1, 0, "R1 push");
    do_op(1, 0, "R6 push full");
    do_op(0, 0, "R1 pop");
    do_op(0, 0, "R1 pop");
    do_op(1, 0, "R10 tail wrap");
    do_op(1, 0, "R10 tail wrap");
    for (int k = 0; k < 4; k++) do_op(0, 0, "R10 head wrap");
    do_op(0, 0, "R6 pop empty");
  endtask

  task automatic t_exposed_alt;
    do_op(1, 0, "R1 push");
    do_op(1, 1, "R5 push_at_head exposed");
    do_op(0, 1, "R5 pop_at_tail exposed");
    do_op(0, 0, "R5 state kept");
  endtask

  task automatic t_message;
    do_cfg(32'h2000, 8, 0, 1, "R4 cfg msg");
    do_op(1, 0, "R4 push");
    do_op(1, 0, "R4 push");
    do_op(1, 1, "R4 push_at_head");
    do_op(0, 1, "R4 pop_at_tail");
    do_op(0, 0, "R4 pop head");
    do_op(0, 1, "R4 pop_at_tail last");
    do_op(0, 1, "R6 pop_at_tail empty");
    do_op(1, 1, "R10 push_at_head wrap back");
  endtask

  task automatic t_cred;
    do_cfg(32'h4000, 4, 1, 2, "R3 cfg cred");
    do_op(1, 0, "R3 cred push");
    do_op(1, 0, "R3 cred step 16");
    do_op(0, 1, "R3 cred pop_at_tail");
  endtask

  task automatic t_both;
    bit err; longint idx;
    do_op(1, 0, "R8 prefill");
    @(negedge clk);
    push_valid = 1; pop_valid = 1;
    #1;
    check("R8", "push_ready with pop", push_ready, 0);
    check("R8", "pop_ready", pop_ready, 1);
    @(posedge clk); #1;
    pop_valid = 0;
    model_op(0, 0, err, idx);
    check_result("R8 pop first", 0, err, idx);
    @(posedge clk); #1;
    push_valid = 0;
    model_op(1, 0, err, idx);
    check_result("R8 push second", 1, err, idx);
  endtask

  task automatic t_clear;
    do_op(1, 0, "R7 fill");
    @(negedge clk); ring_clr = 1;
    @(posedge clk); #1; ring_clr = 0;
    m_head = 0; m_tail = 0; m_occ = 0;
    check("R7", "occupancy after clear", occupancy, 0);
    do_op(1, 0, "R7 push at index 0");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    t_reset;
    t_config;
    t_fill_wrap;
    t_exposed_alt;
    t_message;
    t_cred;
    t_both;
    t_clear;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule